// File: doc/BRIEF.md
# Nine-bit serial receive buffer with controller-clocked readout

This block recovers asynchronous characters from a demodulated serial line that idles high. A 16x oversampling tick paces it. Each character is one low start bit, eight data bits sent least significant first, and one stop bit. The start bit is checked at its middle and then dropped. The data bits and the stop bit are sampled at the middle of their cells and kept. At the middle of the stop bit, all nine bits move in one step into an output shift register, and an active-low ready strobe falls.

An external controller reads the character by pulsing a read clock input. The register presents the first received bit on the data output at once. Each synchronised rising edge of the read clock advances the output to the next bit. A controller that does not check framing stops after eight pulses. One that does reads the stop bit as the ninth value. The ready strobe clears itself on the first read-clock edge, or after half a bit time if no edge arrives. A controller can therefore use it as an interrupt that its first read acknowledges.

Top module: `rx_nine_buffer`

## Requirements
- R1: After reset, `rdy_n` is high and `sdata` is high.
- R2: For each character received, `rdy_n` falls once, near the middle of the stop bit. In the same cycle, `sdata` shows received data bit 0, the first bit after the start bit.
- R3: The nine held bits leave in arrival order: data bits 0 to 7, then the stop bit. The controller samples `sdata` before each read pulse, and each synchronised rising edge of `rd_clk` advances `sdata` by one bit.
- R4: A rising edge of `rd_clk` while `rdy_n` is low returns `rdy_n` high.
- R5: With no `rd_clk` edge, `rdy_n` stays low for half a bit time, which is 8 sample ticks, and then returns high on its own.
- R6: The stop bit is stored as received. A stop bit sampled low appears as 0 in the ninth read position, which flags a framing error.
- R7: After all nine bits have been shifted out, `sdata` stays high under further read pulses.
- R8: A low glitch on `rx_line` that is high again by the middle of the would-be start bit starts no character. `rdy_n` does not fall.
- R9: A new character overwrites any unread contents of the shift register. A later read returns only the newest character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Demodulated serial stream; high when idle |
| rd_clk | input | 1 | Read clock from the controller; asynchronous |
| sdata | output | 1 | Serial output of the held character |
| rdy_n | output | 1 | Active-low character-ready strobe |

## Verification
A wrong framing state or bit index appears within one character time. The wrong bit shows on `sdata` during readout, or `rdy_n` falls at the wrong time or not at all. A wrong shift register shows on the first or a later read pulse, as a bit out of order or a missing idle-high fill after the ninth pulse. A stuck hold timer appears half a bit time after the load, as a `rdy_n` low period of the wrong length. The directed scenarios cover these cases:
- several byte patterns;
- a bad stop bit;
- a glitch that must be rejected;
- an unread character that is overwritten;
- a strobe that times out without being read.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_t;

  // ticks from edge detection to the middle of a cell
  function automatic int half_cell(input int os);
    return os / 2;
  endfunction

  // true on the last tick of a window of len ticks counted from zero
  function automatic logic window_end(input int cnt, input int len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // a detected edge is a single-cycle event (R3)
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/rxb_framer.sv
module rxb_framer
  import rxb_pkg::*;
#(
  parameter int OS    = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_in,
  output logic             ld,
  output logic [DBITS:0]   word
);
  localparam int FW   = DBITS + 1;
  localparam int CW   = $clog2(OS);
  localparam int IW   = $clog2(DBITS + 1);
  localparam int HALF = half_cell(OS);

  logic            rx_s1, rx_s2;
  fr_state_t       state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   bidx;
  logic [FW-1:0]   hold;
  logic            ld_q;

  // event wires
  logic cell_mid, start_mid;
  assign cell_mid  = tick && window_end(int'(cnt), OS);
  assign start_mid = tick && window_end(int'(cnt), HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      hold  <= '1;
      ld_q  <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      if (tick) begin
        unique case (state)
          FR_IDLE: begin
            if (!rx_s2) begin
              state <= FR_START;
              cnt   <= '0;
            end
          end
          FR_START: begin
            if (start_mid) begin
              cnt  <= '0;
              bidx <= '0;
              state <= rx_s2 ? FR_IDLE : FR_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cell_mid) begin
              cnt        <= '0;
              hold[bidx] <= rx_s2;
              if (int'(bidx) == DBITS - 1) state <= FR_STOP;
              else                         bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_STOP: begin
            if (cell_mid) begin
              cnt          <= '0;
              hold[FW-1]   <= rx_s2;
              ld_q         <= 1'b1;
              state        <= FR_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end

  assign ld   = ld_q;
  assign word = hold;

  // a load follows only the stop cell (R2)
  assert_load_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> $past(state) == FR_STOP);

  // one load per character (R2)
  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |=> !ld_q);

  // a glitch rejected at the start midpoint returns to idle (R8)
  assert_glitch_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_START && start_mid && rx_s2) |=> state == FR_IDLE && !ld_q);

endmodule

// File: rtl/rxb_shifter.sv
module rxb_shifter
  import rxb_pkg::*;
#(
  parameter int OS    = 16,
  parameter int DBITS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           ld,
  input  logic [DBITS:0] word,
  input  logic           rd_rise,
  output logic           data,
  output logic           rdy_n
);
  localparam int FW   = DBITS + 1;
  localparam int HALF = half_cell(OS);
  localparam int TW   = $clog2(HALF + 1);

  logic [FW-1:0] sr;
  logic [TW-1:0] tmr;
  logic          shift_ev, hold_over;

  assign shift_ev  = rd_rise && !ld;
  assign hold_over = tick && window_end(int'(tmr), HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '1;
    else if (ld)        sr <= word;
    else if (shift_ev)  sr <= {1'b1, sr[FW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n <= 1'b1;
      tmr   <= '0;
    end else if (ld) begin
      rdy_n <= 1'b0;
      tmr   <= '0;
    end else if (!rdy_n) begin
      if (rd_rise || hold_over) rdy_n <= 1'b1;
      if (tick)                 tmr   <= tmr + 1'b1;
    end
  end

  assign data = sr[0];

  // checker: ticks spent low since the last load
  logic [TW:0] chk_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chk_low <= '0;
    else if (ld)                chk_low <= '0;
    else if (!rdy_n && tick)    chk_low <= chk_low + 1'b1;
  end

  // load drives the strobe low and shows the first bit (R2)
  assert_load_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !rdy_n && data == $past(word[0]));

  // first read edge clears the strobe (R4)
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && rd_rise && !ld) |=> rdy_n);

  // strobe never outlasts half a cell (R5)
  assert_low_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> int'(chk_low) <= HALF);

  // shifting fills with idle ones (R7)
  assert_idle_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> $countones(sr) >= $past($countones(sr)));

endmodule

// File: rtl/rx_nine_buffer.sv
module rx_nine_buffer #(
  parameter int OS    = 16,
  parameter int DBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic rx_line,
  input  logic rd_clk,
  output logic sdata,
  output logic rdy_n
);
  logic           ld;
  logic [DBITS:0] word;
  logic           rd_rise;

  rxb_sync u_rd_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (rd_clk),
    .rise     (rd_rise)
  );

  rxb_framer #(.OS(OS), .DBITS(DBITS)) u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .rx_in (rx_line),
    .ld    (ld),
    .word  (word)
  );

  rxb_shifter #(.OS(OS), .DBITS(DBITS)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .ld      (ld),
    .word    (word),
    .rd_rise (rd_rise),
    .data    (sdata),
    .rdy_n   (rdy_n)
  );

endmodule

// File: tb/test_rx_nine_buffer.sv
`timescale 1ns/1ps
module test_rx_nine_buffer;
  localparam int DIV = 4;            // clocks per sample tick
  localparam int BIT = 16 * DIV;     // clocks per bit cell

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rx_line = 1'b1;
  logic rd_clk = 1'b0;
  logic sdata, rdy_n;

  int pass_n = 0;
  int fail_n = 0;
  int tdiv = 0;
  int falls = 0;
  int low_run = 0;
  int last_low = 0;
  int cycles = 0;
  logic prev_rdy = 1'b1;

  always #2 clk = ~clk;

  rx_nine_buffer i_rx_nine_buffer (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .rd_clk(rd_clk), .sdata(sdata), .rdy_n(rdy_n)
  );

  always @(posedge clk) begin
    tdiv   <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == DIV - 2);
  end

  always @(negedge clk) begin
    if (prev_rdy && !rdy_n) begin falls <= falls + 1; low_run <= 1; end
    else if (!rdy_n) low_run <= low_run + 1;
    if (!prev_rdy && rdy_n) last_low <= low_run;
    prev_rdy <= rdy_n;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: act=hung exp=done");
      fail_n = fail_n + 1;
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopv);
    rx_line = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      repeat (BIT) @(negedge clk);
    end
    rx_line = stopv;
  endtask

  task automatic wait_fall(input string req, input logic exp0);
    int f0 = falls;
    int n = 0;
    while (falls == f0 && n < 4 * BIT) begin @(negedge clk); n++; end
    chk(falls != f0, req, falls - f0, 1);
    chk(sdata == exp0, req, sdata, exp0);   // first bit shown at load
    rx_line = 1'b1;
  endtask

  task automatic pulse();
    rd_clk = 1'b1; repeat (DIV) @(negedge clk);
    rd_clk = 1'b0; repeat (DIV) @(negedge clk);
  endtask

  task automatic read_nine(input logic [8:0] exp, input bit chk_rel, input string req);
    for (int k = 0; k < 9; k++) begin
      chk(sdata == exp[k], req, sdata, exp[k]);
      pulse();
      if (k == 0 && chk_rel) chk(rdy_n == 1'b1, "R4", rdy_n, 1);
    end
    chk(sdata == 1'b1, "R7", sdata, 1);
  endtask

  task automatic idle_line();
    rx_line = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rdy_n == 1'b1, "R1", rdy_n, 1);
    chk(sdata == 1'b1, "R1", sdata, 1);
  endtask

  task automatic t_byte(input logic [7:0] d);
    send_frame(d, 1'b1);
    wait_fall("R2", d[0]);
    read_nine({1'b1, d}, 1'b1, "R3");
    idle_line();
  endtask

  task automatic t_timeout();
    send_frame(8'h5A, 1'b1);
    wait_fall("R2", 1'b0);
    repeat (12 * DIV) @(negedge clk);
    chk(rdy_n == 1'b1, "R5", rdy_n, 1);
    chk(last_low >= 7 * DIV + 1 && last_low <= 8 * DIV + 1, "R5", last_low, 8 * DIV);
    read_nine({1'b1, 8'h5A}, 1'b0, "R3");
    idle_line();
  endtask

  task automatic t_framing();
    send_frame(8'h96, 1'b0);
    wait_fall("R6", 1'b0);
    read_nine({1'b0, 8'h96}, 1'b1, "R6");
    idle_line();
  endtask

  task automatic t_overwrite();
    send_frame(8'h11, 1'b1);
    wait_fall("R9", 1'b1);
    idle_line();
    send_frame(8'hEE, 1'b1);
    wait_fall("R9", 1'b0);
    read_nine({1'b1, 8'hEE}, 1'b1, "R9");
    idle_line();
  endtask

  task automatic t_extra_pulse();
    pulse();
    pulse();
    chk(sdata == 1'b1, "R7", sdata, 1);
  endtask

  task automatic t_glitch();
    int f0 = falls;
    rx_line = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk(falls == f0, "R8", falls - f0, 0);
    chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    chk(sdata == 1'b1, "R8", sdata, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    idle_line();
    t_byte(8'hA5);
    t_byte(8'h3C);
    t_byte(8'h01);
    t_byte(8'hFF);
    t_timeout();
    t_framing();
    t_overwrite();
    t_extra_pulse();
    t_glitch();
    t_byte(8'h80);
    summary();
  end

endmodule